// File: doc/BRIEF.md
# SDRAM Command Sequencer

This block turns single-word host requests into the command stream of a two-bank, 16-bit synchronous DRAM. A host presents a valid request with a read/write flag, a 20-bit word address, write data and byte enables. The sequencer opens the addressed row, issues one column access with automatic precharge, and for reads returns the captured word with a one-cycle valid strobe. Every request therefore opens and closes its row, so no page is held open between requests.

After reset the block runs the device start-up sequence by itself. It waits out the power-up pause, precharges both banks, issues two auto refresh cycles and loads the mode register. From then on it keeps a free-running refresh timer that fires once per 1/4096 of 64 ms. A due refresh is served from the idle state ahead of any waiting host request. All command, address and mask pins are driven from registers. The clock enable is held high, and the timing gaps between commands are counted in clock cycles set by parameters.

Top module: `sdr_sequencer`

## Requirements
- R1: While reset is held, CS# is high (deselect) and CKE is low; from the first cycle after reset CKE is high and never falls again.
- R2: After reset only NOP/deselect appears for exactly INIT_US×CLK_MHZ cycles. Next comes a precharge-all (A10 high), then two auto refresh commands, then one mode register write. reqReady stays low until that sequence is done.
- R3: The mode register write drives BA=0 and an address word with A[2:0]=000 (burst of one), A3=0 (sequential order), A[6:4] equal to CAS_LAT and every other bit zero.
- R4: At activate, BA is reqAddr[19] and A10..A0 is reqAddr[18:8]. At the following read or write, BA repeats that bank, A7..A0 is reqAddr[7:0] and A10 is high (auto-precharge).
- R5: Commands are encoded on {CS#,RAS#,CAS#,WE#} as: mode write 0000, refresh 0001, precharge 0010, activate 0011, write 0100, read 0101, NOP 0111. Every cycle with no command carries NOP.
- R6: A read or write is issued at least T_RCD cycles after its activate. Any activate or refresh comes at least T_RC cycles after the previous activate or refresh, at least T_WR+T_RP cycles after a write, and at least CAS_LAT+T_RP cycles after a read. Refresh follows precharge by at least T_RP, and the first command after the mode write follows it by at least T_MRD.
- R7: In the write command cycle the data bus is driven with the request data and DQM[1] (upper byte) and DQM[0] (lower byte) equal the inverted byte enables reqBe[1] and reqBe[0]. In all other cycles the bus is not driven.
- R8: For a read, rdValid is high for one cycle exactly CAS_LAT+1 cycles after the read command cycle. rdData then holds the word the device drove CAS_LAT cycles after that command.
- R9: With the host idle, consecutive auto refresh commands are exactly REF_NS×CLK_MHZ/1000 cycles apart.
- R10: If a refresh falls due in the same cycle that a request is waiting, the refresh is issued first. reqReady is low in that cycle, and the activate follows the refresh by T_RC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Host request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 20 | Word address: bank, row, column |
| reqWdata | input | 16 | Write data |
| reqBe | input | 2 | Byte enables, bit 1 upper byte |
| reqReady | output | 1 | Request accepted at this edge when valid |
| rdData | output | 16 | Read word |
| rdValid | output | 1 | rdData valid strobe |
| sdrCsN | output | 1 | Chip select, active low |
| sdrRasN | output | 1 | Row strobe, active low |
| sdrCasN | output | 1 | Column strobe, active low |
| sdrWeN | output | 1 | Write enable, active low |
| sdrBa | output | 1 | Bank select |
| sdrAddr | output | 11 | Multiplexed row/column/mode address |
| sdrDqm | output | 2 | Byte masks, bit 1 upper |
| sdrCke | output | 1 | Clock enable |
| sdrDqOut | output | 16 | Data to device |
| sdrDqOe | output | 1 | Data bus drive enable |
| sdrDqIn | input | 16 | Data from device |

## Verification
The refresh timer and a host request can both want the idle slot in the same cycle. The bench measures the steady refresh period while the host is idle, predicts the next refresh cycle, and raises a write request exactly in the decision cycle before it. The run is judged correct if the refresh lands on the predicted cycle and the activate comes T_RC cycles later, not in the refresh's place. The written word must then read back intact.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;
  // {CS#, RAS#, CAS#, WE#}
  typedef enum logic [3:0] {
    CMD_MRS   = 4'b0000,
    CMD_REF   = 4'b0001,
    CMD_PRE   = 4'b0010,
    CMD_ACT   = 4'b0011,
    CMD_WR    = 4'b0100,
    CMD_RD    = 4'b0101,
    CMD_NOP   = 4'b0111,
    CMD_DESEL = 4'b1111
  } sdrCmd_e;

  typedef struct packed {
    logic act;
    logic rd;
    logic wr;
    logic preAll;
    logic autoRef;
    logic mrs;
  } seqStrobe_t;
endpackage

// File: rtl/sdr_seq_ctrl.sv
module sdr_seq_ctrl
  import sdr_seq_pkg::*;
#(
  parameter int CLK_MHZ = 100,
  parameter int INIT_US = 200,
  parameter int REF_NS  = 15625,
  parameter int CAS_LAT = 3,
  parameter int T_RCD   = 2,
  parameter int T_RP    = 2,
  parameter int T_RC    = 6,
  parameter int T_MRD   = 2,
  parameter int T_WR    = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       reqValid,
  input  logic       reqWrite,
  output logic       reqReady,
  output seqStrobe_t strobe
);
  localparam int INIT_CYC = INIT_US * CLK_MHZ;
  localparam int REF_CYC  = (REF_NS * CLK_MHZ) / 1000;
  localparam int RC_REST  = T_RC - T_RCD;
  localparam int WR_REC   = T_WR + T_RP;
  localparam int RD_REC   = CAS_LAT + T_RP;
  localparam int WR_GAP   = (WR_REC > RC_REST) ? WR_REC : RC_REST;
  localparam int RD_GAP   = (RD_REC > RC_REST) ? RD_REC : RC_REST;
  localparam int WAIT_W   = $clog2(INIT_CYC + T_RC + WR_GAP + RD_GAP + T_MRD + 1);
  localparam int REF_W    = $clog2(REF_CYC + 1);

  typedef enum logic [2:0] {ST_PWR, ST_IREF, ST_MRS, ST_IDLE, ST_RW} seqState_e;

  seqState_e state, nextState;
  logic [WAIT_W-1:0] waitCnt, loadVal;
  logic [REF_W-1:0]  refCnt;
  logic load, refPend, refTake, acceptReq, initRefs, isWrite;

  always_comb begin
    strobe    = '0;
    nextState = state;
    load      = 1'b0;
    loadVal   = '0;
    refTake   = 1'b0;
    acceptReq = 1'b0;
    if (waitCnt == '0) begin
      unique case (state)
        ST_PWR: begin
          strobe.preAll = 1'b1;
          load = 1'b1; loadVal = WAIT_W'(T_RP - 1);
          nextState = ST_IREF;
        end
        ST_IREF: begin
          strobe.autoRef = 1'b1;
          load = 1'b1; loadVal = WAIT_W'(T_RC - 1);
          if (initRefs) nextState = ST_MRS;
        end
        ST_MRS: begin
          strobe.mrs = 1'b1;
          load = 1'b1; loadVal = WAIT_W'(T_MRD - 1);
          nextState = ST_IDLE;
        end
        ST_IDLE: begin
          if (refPend) begin
            strobe.autoRef = 1'b1;
            load = 1'b1; loadVal = WAIT_W'(T_RC - 1);
            refTake = 1'b1;
          end else if (reqValid) begin
            strobe.act = 1'b1;
            load = 1'b1; loadVal = WAIT_W'(T_RCD - 1);
            acceptReq = 1'b1;
            nextState = ST_RW;
          end
        end
        ST_RW: begin
          strobe.wr = isWrite;
          strobe.rd = ~isWrite;
          load = 1'b1;
          loadVal = isWrite ? WAIT_W'(WR_GAP - 1) : WAIT_W'(RD_GAP - 1);
          nextState = ST_IDLE;
        end
        default: nextState = ST_PWR;
      endcase
    end
  end

  assign reqReady = (state == ST_IDLE) && (waitCnt == '0) && !refPend;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_PWR;
      waitCnt  <= WAIT_W'(INIT_CYC - 1);
      initRefs <= 1'b0;
      isWrite  <= 1'b0;
    end else begin
      state <= nextState;
      if (load) waitCnt <= loadVal;
      else if (waitCnt != '0) waitCnt <= waitCnt - 1'b1;
      if (state == ST_IREF && strobe.autoRef) initRefs <= 1'b1;
      if (acceptReq) isWrite <= reqWrite;
    end
  end

  // free-running refresh pacing
  always_ff @(posedge clk) begin
    if (rst) begin
      refCnt  <= REF_W'(REF_CYC - 1);
      refPend <= 1'b0;
    end else begin
      if (refTake) refPend <= 1'b0;
      if (refCnt == '0) begin
        refCnt  <= REF_W'(REF_CYC - 1);
        refPend <= 1'b1;
      end else begin
        refCnt <= refCnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/sdr_seq_dpath.sv
module sdr_seq_dpath
  import sdr_seq_pkg::*;
#(
  parameter int ROW_W   = 11,
  parameter int COL_W   = 8,
  parameter int DATA_W  = 16,
  parameter int CAS_LAT = 3,
  localparam int ADDR_W = 1 + ROW_W + COL_W,
  localparam int BE_W   = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  seqStrobe_t        strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [BE_W-1:0]   reqBe,
  output logic              sdrCsN,
  output logic              sdrRasN,
  output logic              sdrCasN,
  output logic              sdrWeN,
  output logic              sdrBa,
  output logic [ROW_W-1:0]  sdrAddr,
  output logic [BE_W-1:0]   sdrDqm,
  output logic              sdrCke,
  output logic [DATA_W-1:0] sdrDqOut,
  output logic              sdrDqOe,
  input  logic [DATA_W-1:0] sdrDqIn,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);
  localparam int AP_BIT = 10;
  localparam logic [ROW_W-1:0] MODE_WORD = ROW_W'(CAS_LAT * 16);

  sdrCmd_e           cmdQ, cmdNext;
  logic              bankLat;
  logic [COL_W-1:0]  colLat;
  logic [DATA_W-1:0] wdataLat;
  logic [BE_W-1:0]   beLat;
  logic [ROW_W-1:0]  colWord, addrNext, precharge;
  logic              baNext;
  logic [CAS_LAT:0]  rdPipe;

  always_comb begin
    colWord = '0;
    colWord[COL_W-1:0] = colLat;
    colWord[AP_BIT] = 1'b1;
    precharge = '0;
    precharge[AP_BIT] = 1'b1;
  end

  always_comb begin
    cmdNext  = CMD_NOP;
    addrNext = '0;
    baNext   = 1'b0;
    if (strobe.act) begin
      cmdNext  = CMD_ACT;
      addrNext = reqAddr[COL_W +: ROW_W];
      baNext   = reqAddr[ADDR_W-1];
    end else if (strobe.rd || strobe.wr) begin
      cmdNext  = strobe.wr ? CMD_WR : CMD_RD;
      addrNext = colWord;
      baNext   = bankLat;
    end else if (strobe.preAll) begin
      cmdNext  = CMD_PRE;
      addrNext = precharge;
    end else if (strobe.autoRef) begin
      cmdNext  = CMD_REF;
    end else if (strobe.mrs) begin
      cmdNext  = CMD_MRS;
      addrNext = MODE_WORD;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmdQ     <= CMD_DESEL;
      sdrAddr  <= '0;
      sdrBa    <= 1'b0;
      sdrDqm   <= '0;
      sdrDqOe  <= 1'b0;
      sdrDqOut <= '0;
      sdrCke   <= 1'b0;
      bankLat  <= 1'b0;
      colLat   <= '0;
      wdataLat <= '0;
      beLat    <= '0;
    end else begin
      cmdQ     <= cmdNext;
      sdrAddr  <= addrNext;
      sdrBa    <= baNext;
      sdrCke   <= 1'b1;
      sdrDqOe  <= strobe.wr;
      sdrDqm   <= strobe.wr ? ~beLat : '0;
      if (strobe.wr) sdrDqOut <= wdataLat;
      if (strobe.act) begin
        bankLat  <= reqAddr[ADDR_W-1];
        colLat   <= reqAddr[COL_W-1:0];
        wdataLat <= reqWdata;
        beLat    <= reqBe;
      end
    end
  end

  assign {sdrCsN, sdrRasN, sdrCasN, sdrWeN} = cmdQ;

  // read return: capture CAS_LAT cycles after the command is on the pins
  always_ff @(posedge clk) begin
    if (rst) begin
      rdPipe  <= '0;
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdPipe  <= {rdPipe[CAS_LAT-1:0], strobe.rd};
      rdValid <= rdPipe[CAS_LAT];
      if (rdPipe[CAS_LAT]) rdData <= sdrDqIn;
    end
  end
endmodule

// File: rtl/sdr_sequencer.sv
module sdr_sequencer
  import sdr_seq_pkg::*;
#(
  parameter int CLK_MHZ = 100,
  parameter int INIT_US = 200,
  parameter int REF_NS  = 15625,
  parameter int CAS_LAT = 3,
  parameter int T_RCD   = 2,
  parameter int T_RP    = 2,
  parameter int T_RC    = 6,
  parameter int T_MRD   = 2,
  parameter int T_WR    = 2,
  parameter int ROW_W   = 11,
  parameter int COL_W   = 8,
  parameter int DATA_W  = 16,
  localparam int ADDR_W = 1 + ROW_W + COL_W,
  localparam int BE_W   = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [BE_W-1:0]   reqBe,
  output logic              reqReady,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              sdrCsN,
  output logic              sdrRasN,
  output logic              sdrCasN,
  output logic              sdrWeN,
  output logic              sdrBa,
  output logic [ROW_W-1:0]  sdrAddr,
  output logic [BE_W-1:0]   sdrDqm,
  output logic              sdrCke,
  output logic [DATA_W-1:0] sdrDqOut,
  output logic              sdrDqOe,
  input  logic [DATA_W-1:0] sdrDqIn
);
  seqStrobe_t strobe;

  sdr_seq_ctrl #(
    .CLK_MHZ(CLK_MHZ), .INIT_US(INIT_US), .REF_NS(REF_NS), .CAS_LAT(CAS_LAT),
    .T_RCD(T_RCD), .T_RP(T_RP), .T_RC(T_RC), .T_MRD(T_MRD), .T_WR(T_WR)
  ) ctrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .strobe(strobe)
  );

  sdr_seq_dpath #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .CAS_LAT(CAS_LAT)
  ) dpath (
    .clk(clk), .rst(rst), .strobe(strobe), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .reqBe(reqBe),
    .sdrCsN(sdrCsN), .sdrRasN(sdrRasN), .sdrCasN(sdrCasN), .sdrWeN(sdrWeN),
    .sdrBa(sdrBa), .sdrAddr(sdrAddr), .sdrDqm(sdrDqm), .sdrCke(sdrCke),
    .sdrDqOut(sdrDqOut), .sdrDqOe(sdrDqOe), .sdrDqIn(sdrDqIn),
    .rdData(rdData), .rdValid(rdValid)
  );
endmodule

// File: rtl/sdr_sequencer_chk.sv
module sdr_sequencer_chk
  import sdr_seq_pkg::*;
#(
  parameter int CAS_LAT = 3,
  parameter int T_RCD   = 2,
  parameter int T_RC    = 6,
  parameter int ROW_W   = 11
) (
  input logic             clk,
  input logic             rst,
  input logic             sdrCsN,
  input logic             sdrRasN,
  input logic             sdrCasN,
  input logic             sdrWeN,
  input logic             sdrBa,
  input logic [ROW_W-1:0] sdrAddr,
  input logic             sdrCke,
  input logic             sdrDqOe,
  input logic             rdValid,
  input logic             reqReady
);
  logic [3:0] cmdNow;
  logic [7:0] sinceAct, sinceRef;
  logic       mrsSeen, isRd, isRw;

  assign cmdNow = {sdrCsN, sdrRasN, sdrCasN, sdrWeN};
  assign isRd   = (cmdNow == CMD_RD);
  assign isRw   = (cmdNow == CMD_RD) || (cmdNow == CMD_WR);

  always_ff @(posedge clk) begin
    if (rst) begin
      sinceAct <= 8'hFF;
      sinceRef <= 8'hFF;
      mrsSeen  <= 1'b0;
    end else begin
      sinceAct <= (cmdNow == CMD_ACT) ? 8'd1 : ((sinceAct == 8'hFF) ? sinceAct : sinceAct + 8'd1);
      sinceRef <= (cmdNow == CMD_REF) ? 8'd1 : ((sinceRef == 8'hFF) ? sinceRef : sinceRef + 8'd1);
      if (cmdNow == CMD_MRS) mrsSeen <= 1'b1;
    end
  end

  a_r1_cke_held: assert property (@(posedge clk) disable iff (rst)
    $past(sdrCke) |-> sdrCke);

  a_r2_ready_after_mode: assert property (@(posedge clk) disable iff (rst)
    reqReady |-> mrsSeen);

  a_r3_mode_word: assert property (@(posedge clk) disable iff (rst)
    (cmdNow == CMD_MRS) |-> (sdrAddr == ROW_W'(CAS_LAT * 16)) && !sdrBa);

  a_r4_auto_precharge: assert property (@(posedge clk) disable iff (rst)
    isRw |-> sdrAddr[10]);

  a_r6_rcd_gap: assert property (@(posedge clk) disable iff (rst)
    isRw |-> (sinceAct >= 8'(T_RCD)));

  a_r6_rc_gap: assert property (@(posedge clk) disable iff (rst)
    ((cmdNow == CMD_ACT) || (cmdNow == CMD_REF)) |-> (sinceAct >= 8'(T_RC)) && (sinceRef >= 8'(T_RC)));

  a_r7_bus_only_on_write: assert property (@(posedge clk) disable iff (rst)
    sdrDqOe |-> (cmdNow == CMD_WR));

  a_r8_read_latency: assert property (@(posedge clk) disable iff (rst)
    rdValid |-> $past(isRd, CAS_LAT + 1));
endmodule

bind sdr_sequencer sdr_sequencer_chk #(
  .CAS_LAT(CAS_LAT), .T_RCD(T_RCD), .T_RC(T_RC), .ROW_W(ROW_W)
) chk (
  .clk(clk), .rst(rst), .sdrCsN(sdrCsN), .sdrRasN(sdrRasN), .sdrCasN(sdrCasN),
  .sdrWeN(sdrWeN), .sdrBa(sdrBa), .sdrAddr(sdrAddr), .sdrCke(sdrCke),
  .sdrDqOe(sdrDqOe), .rdValid(rdValid), .reqReady(reqReady)
);

// File: tb/sdr_sequencer_test.sv
module sdr_sequencer_test;
  import sdr_seq_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_MHZ = 10, INIT_US = 200, REF_NS = 15625, CL = 2;
  localparam int T_RCD = 2, T_RP = 2, T_RC = 6, T_MRD = 2, T_WR = 2;
  localparam int INIT_CYC = INIT_US * CLK_MHZ;
  localparam int REF_CYC  = (REF_NS * CLK_MHZ) / 1000;

  logic clk = 0, rst = 1;
  logic reqValid = 0, reqWrite = 0;
  logic [19:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic [1:0]  reqBe = '0;
  logic reqReady, rdValid;
  logic [15:0] rdData;
  logic sdrCsN, sdrRasN, sdrCasN, sdrWeN, sdrBa, sdrCke, sdrDqOe;
  logic [10:0] sdrAddr;
  logic [1:0]  sdrDqm;
  logic [15:0] sdrDqOut;
  logic [15:0] sdrDqIn = '0;

  sdr_sequencer #(
    .CLK_MHZ(CLK_MHZ), .INIT_US(INIT_US), .REF_NS(REF_NS), .CAS_LAT(CL),
    .T_RCD(T_RCD), .T_RP(T_RP), .T_RC(T_RC), .T_MRD(T_MRD), .T_WR(T_WR)
  ) uut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqBe(reqBe), .reqReady(reqReady),
    .rdData(rdData), .rdValid(rdValid), .sdrCsN(sdrCsN), .sdrRasN(sdrRasN),
    .sdrCasN(sdrCasN), .sdrWeN(sdrWeN), .sdrBa(sdrBa), .sdrAddr(sdrAddr),
    .sdrDqm(sdrDqm), .sdrCke(sdrCke), .sdrDqOut(sdrDqOut), .sdrDqOe(sdrDqOe),
    .sdrDqIn(sdrDqIn)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  typedef struct { bit wr; logic bank; logic [7:0] col; logic [15:0] d; logic [1:0] be; } rwExp_t;

  logic [11:0] actQ[$];
  rwExp_t      rwQ[$];
  logic [15:0] rdExpQ[$];
  int          rdTimeQ[$];
  int          refTimes[$];
  logic [15:0] refMem[logic [19:0]];
  logic [15:0] devMem[logic [19:0]];
  logic [10:0] openRow[2];

  int cyc = 0;
  int initStep = 0;
  int lastAct = -1000, lastRef = -1000, lastWr = -1000, lastRd = -1000;
  int lastPre = -1000, lastMrs = -1000;

  // device model and protocol observer: stamp = cycle the pins showed the command
  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else begin
      logic [3:0] c;
      c = {sdrCsN, sdrRasN, sdrCasN, sdrWeN};
      cyc <= cyc + 1;
      case (c)
        CMD_NOP, CMD_DESEL: ;
        CMD_PRE: begin
          check(initStep == 0, "R2 precharge order", initStep, 0);
          check(cyc == INIT_CYC, "R2 power-up wait", cyc, INIT_CYC);
          check(sdrAddr[10], "R2 precharge all", sdrAddr, 11'h400);
          initStep = 1; lastPre = cyc;
        end
        CMD_REF: begin
          check(cyc - lastPre >= T_RP, "R6 precharge to refresh", cyc - lastPre, T_RP);
          check(cyc - lastRef >= T_RC, "R6 refresh to refresh", cyc - lastRef, T_RC);
          check(cyc - lastAct >= T_RC, "R6 activate to refresh", cyc - lastAct, T_RC);
          check(cyc - lastWr >= T_WR + T_RP, "R6 write to refresh", cyc - lastWr, T_WR + T_RP);
          check(cyc - lastRd >= CL + T_RP, "R6 read to refresh", cyc - lastRd, CL + T_RP);
          if (initStep == 4) begin
            check(cyc - lastMrs >= T_MRD, "R6 mode to refresh", cyc - lastMrs, T_MRD);
            refTimes.push_back(cyc);
          end else begin
            check(initStep == 1 || initStep == 2, "R2 refresh order", initStep, 1);
            initStep++;
          end
          lastRef = cyc;
        end
        CMD_MRS: begin
          check(initStep == 3, "R2 mode after two refreshes", initStep, 3);
          check(sdrAddr == 11'(CL << 4), "R3 mode word", sdrAddr, CL << 4);
          check(sdrBa == 1'b0, "R3 mode bank", sdrBa, 0);
          initStep = 4; lastMrs = cyc;
        end
        CMD_ACT: begin
          logic [11:0] e;
          check(initStep == 4, "R2 access before init done", initStep, 4);
          check(cyc - lastMrs >= T_MRD, "R6 mode to activate", cyc - lastMrs, T_MRD);
          check(cyc - lastAct >= T_RC && cyc - lastRef >= T_RC, "R6 tRC", cyc, lastAct + T_RC);
          check(cyc - lastWr >= T_WR + T_RP, "R6 write recovery", cyc - lastWr, T_WR + T_RP);
          check(cyc - lastRd >= CL + T_RP, "R6 read recovery", cyc - lastRd, CL + T_RP);
          e = (actQ.size() > 0) ? actQ.pop_front() : 12'hFFF;
          check({sdrBa, sdrAddr} == e, "R4 bank/row at activate", {sdrBa, sdrAddr}, e);
          openRow[sdrBa] = sdrAddr;
          lastAct = cyc;
        end
        CMD_WR, CMD_RD: begin
          rwExp_t e;
          logic [19:0] key;
          bit wrNow;
          wrNow = (c == CMD_WR);
          check(cyc - lastAct >= T_RCD, "R6 tRCD", cyc - lastAct, T_RCD);
          check(sdrAddr[10], "R4 auto-precharge bit", sdrAddr, 11'h400);
          if (rwQ.size() > 0) e = rwQ.pop_front();
          else e = '{wr: 0, bank: 0, col: 0, d: 0, be: 0};
          check(wrNow == e.wr, "R5 read/write code", c, e.wr ? 4 : 5);
          check(sdrBa == e.bank && sdrAddr[7:0] == e.col, "R4 bank/column",
                {sdrBa, sdrAddr[7:0]}, {e.bank, e.col});
          key = {sdrBa, openRow[sdrBa], sdrAddr[7:0]};
          if (wrNow) begin
            logic [15:0] old;
            check(sdrDqOe && sdrDqOut == e.d, "R7 write data", sdrDqOut, e.d);
            check(sdrDqm == ~e.be, "R7 byte masks", sdrDqm, ~e.be);
            old = devMem.exists(key) ? devMem[key] : 16'h0;
            if (!sdrDqm[1]) old[15:8] = sdrDqOut[15:8];
            if (!sdrDqm[0]) old[7:0]  = sdrDqOut[7:0];
            devMem[key] = old;
            lastWr = cyc;
          end else begin
            logic [15:0] v;
            v = devMem.exists(key) ? devMem[key] : 16'h0;
            rdTimeQ.push_back(cyc);
            fork
              begin
                logic [15:0] vv;
                vv = v;
                repeat (CL - 1) @(posedge clk);
                #1 sdrDqIn = vv;
              end
            join_none
            lastRd = cyc;
          end
        end
        default: check(0, "R5 unknown command", c, 7);
      endcase
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && rdValid) begin
      logic [15:0] e;
      int t;
      e = (rdExpQ.size() > 0) ? rdExpQ.pop_front() : 16'hDEAD;
      t = (rdTimeQ.size() > 0) ? rdTimeQ.pop_front() : -1;
      check(rdData == e, "R8 read data", rdData, e);
      check(cyc == t + CL + 1, "R8 read latency", cyc - t, CL + 1);
    end
  end

  task automatic hostReq(input bit wr, input logic [19:0] a, input logic [15:0] d,
                         input logic [1:0] be, input bit skipSync);
    rwExp_t e;
    actQ.push_back({a[19], a[18:8]});
    e.wr = wr; e.bank = a[19]; e.col = a[7:0]; e.d = d; e.be = be;
    rwQ.push_back(e);
    if (wr) begin
      logic [15:0] m;
      m = refMem.exists(a) ? refMem[a] : 16'h0;
      if (be[1]) m[15:8] = d[15:8];
      if (be[0]) m[7:0]  = d[7:0];
      refMem[a] = m;
    end else begin
      rdExpQ.push_back(refMem.exists(a) ? refMem[a] : 16'h0);
    end
    if (!skipSync) @(posedge clk);
    #1;
    reqValid = 1; reqWrite = wr; reqAddr = a; reqWdata = d; reqBe = be;
    do @(negedge clk); while (!reqReady);
    @(posedge clk);
    #1 reqValid = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    end
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(sdrCsN == 1'b1 && sdrCke == 1'b0, "R1 reset pins", {sdrCsN, sdrCke}, 2'b10);
    @(posedge clk); #1 rst = 0;
    repeat (2) @(negedge clk);
    check(sdrCke == 1'b1, "R1 cke high", sdrCke, 1);
    check(reqReady == 1'b0, "R2 busy during init", reqReady, 0);
    wait (initStep == 4);
    while (!reqReady) @(negedge clk);

    // writes: both banks, full and partial byte enables
    hostReq(1, 20'h00012, 16'hA1B2, 2'b11, 0);
    hostReq(1, {1'b1, 11'h5A3, 8'hFF}, 16'h1357, 2'b11, 0);
    hostReq(1, {1'b1, 11'h7FF, 8'h00}, 16'hFFFF, 2'b11, 0);
    hostReq(1, {1'b1, 11'h7FF, 8'h00}, 16'h00C3, 2'b01, 0);
    hostReq(1, {1'b0, 11'h001, 8'h80}, 16'h9900, 2'b10, 0);
    hostReq(1, {1'b0, 11'h001, 8'h80}, 16'h5555, 2'b00, 0);
    // reads back, including an untouched word
    hostReq(0, 20'h00012, 16'h0, 2'b11, 0);
    hostReq(0, {1'b1, 11'h5A3, 8'hFF}, 16'h0, 2'b11, 0);
    hostReq(0, {1'b1, 11'h7FF, 8'h00}, 16'h0, 2'b11, 0);
    hostReq(0, {1'b0, 11'h001, 8'h80}, 16'h0, 2'b11, 0);
    hostReq(0, {1'b0, 11'h2AA, 8'h55}, 16'h0, 2'b11, 0);
    repeat (20) @(posedge clk);

    // R9: refresh period with idle host
    begin
      int n0;
      n0 = refTimes.size();
      wait (refTimes.size() >= n0 + 3);
      check(refTimes[n0 + 1] - refTimes[n0] == REF_CYC, "R9 refresh period",
            refTimes[n0 + 1] - refTimes[n0], REF_CYC);
      check(refTimes[n0 + 2] - refTimes[n0 + 1] == REF_CYC, "R9 refresh period",
            refTimes[n0 + 2] - refTimes[n0 + 1], REF_CYC);
    end

    // R10: request raised in the refresh decision cycle
    begin
      int s;
      s = refTimes[$] + REF_CYC;
      wait (cyc == s - 1);
      fork
        begin
          #2;
          @(negedge clk);
          check(reqReady == 1'b0, "R10 ready low while refresh due", reqReady, 0);
        end
      join_none
      hostReq(1, {1'b1, 11'h123, 8'h45}, 16'hBEEF, 2'b11, 1);
      repeat (4) @(posedge clk);
      check(refTimes[$] == s, "R10 refresh on time", refTimes[$], s);
      check(lastAct == s + T_RC, "R10 activate after refresh", lastAct, s + T_RC);
      hostReq(0, {1'b1, 11'h123, 8'h45}, 16'h0, 2'b11, 0);
    end

    repeat (20) @(posedge clk);
    check(rdExpQ.size() == 0, "R8 all reads returned", rdExpQ.size(), 0);
    check(actQ.size() == 0 && rwQ.size() == 0, "R4 all requests issued", actQ.size(), 0);
    check(sdrCke == 1'b1, "R1 cke still high", sdrCke, 1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule